// File: doc/BRIEF.md
# Configurable CRC-16/CRC-32 Engine

A register-mapped CRC accelerator on a 32-bit bus with byte enables. Software selects the algorithm, preloads a seed, and then streams data into an input register. Each input write holds one, two or four bytes, picked by the byte enables, and all of them are folded into the running CRC at the next clock edge, so back-to-back writes never stall. The result register can be read at any time.

A control register sets four things: the polynomial width (32-bit or 16-bit), bit reversal of each input byte and of the result, the order in which the enabled input bytes are consumed, and byte swapping of the result on read. The swap depends on the width of the read. A 512-word window higher in the address space is an alias of the input register, so a plain block copy can feed the engine. Reads return data in the same cycle, with no wait states.

Top module: `crc_engine`

## Requirements
- R1: After reset, the control register reads 0 and the result reads 0. A control value of 0 selects CRC-32, no reversal, least-significant-lane-first input and no swap.
- R2: With control bit 0 clear, every input byte is shifted MSB-first through the polynomial 0x04C11DB7 over a 32-bit state. After seed 0xFFFFFFFF, the bytes 0x31..0x39 read back as 0x0376E6E7.
- R3: With control bit 0 set, every input byte is shifted MSB-first through the polynomial 0x1021 over a 16-bit state, and result reads return zero in bits 31:16. After seed 0xFFFF, the bytes 0x31..0x39 read back as 0x29B1.
- R4: A write to the seed register (offset 0x004) loads the state at that clock edge, and a result read in the next cycle returns the seed. In 16-bit mode only wdata[15:0] is kept.
- R5: A write to the input register (offset 0x008) folds every byte whose enable is set (lane i = wdata[8i+7:8i], enable be[i]) in one clock. Consecutive writes in consecutive cycles all fold. No other access changes the state.
- R6: With control bit 2 clear, the enabled lanes are consumed from lowest to highest. With control bit 2 set, they are consumed from highest to lowest.
- R7: With control bit 1 set, each input byte is bit-reversed before it enters the generator, and a result read returns the state bit-reversed over the active width (32 or 16 bits).
- R8: With control bit 4 set, a result read with be=4'b1111 in 32-bit mode returns the four bytes in reverse order. A read with any other be swaps the two bytes inside each 16-bit half. In 16-bit mode any read returns {16'h0, r[7:0], r[15:8]}.
- R9: Word-aligned writes to 0x1800 + 4*y, for y from 0 to 511, act exactly like writes to the input register.
- R10: Writing the control register never changes the CRC state. A later result read shows the same state, formatted under the new settings.
- R11: The control register (offset 0x000) is written from byte lane 0 only, when be[0] is set. It reads back bits 4, 2, 1 and 0 with every other bit 0. The result register is at offset 0x00C. All other reads return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables; also gives the access width |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle |

## Verification
A corrupted state register, or a byte folded in the wrong order, is visible on the first result read after the write that caused it. The bench therefore reads the result after every access and compares it with its model, so a fault shows up within one cycle. Formatting faults in reversal or swapping only show under particular control settings and read widths. For that reason the bench varies the control value, the byte enables and the read width across a long pseudo-random run, in addition to the fixed check values. A fault in the control path that disturbs the state is caught because the state is read under the new settings right after each control write.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int BUS_W   = 32;
  localparam int LANES   = BUS_W / 8;
  localparam logic [31:0] POLY_W32 = 32'h04C11DB7;
  localparam logic [15:0] POLY_W16 = 16'h1021;

  localparam int OFS_CTRL   = 'h000;
  localparam int OFS_SEED   = 'h004;
  localparam int OFS_DIN    = 'h008;
  localparam int OFS_RESULT = 'h00C;

  typedef struct packed {
    logic swap;       // control bit 4
    logic msb_first;  // control bit 2
    logic bitrev;     // control bit 1
    logic poly16;     // control bit 0
  } crc_cfg_t;

  function automatic logic [7:0] rev8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction

  function automatic logic [31:0] rev32(input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = b[31-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] b);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = b[15-i];
    return r;
  endfunction

  // One byte, MSB first, through the selected generator.
  function automatic logic [31:0] fold_byte(input logic [31:0] st,
                                            input logic [7:0] b,
                                            input logic p16);
    logic [31:0] s32;
    logic [15:0] s16;
    s32 = st ^ {b, 24'h0};
    s16 = st[15:0] ^ {b, 8'h0};
    for (int i = 0; i < 8; i++) begin
      s32 = s32[31] ? ((s32 << 1) ^ POLY_W32) : (s32 << 1);
      s16 = s16[15] ? ((s16 << 1) ^ POLY_W16) : (s16 << 1);
    end
    return p16 ? {16'h0, s16} : s32;
  endfunction

  // Result presentation: width mask, reversal, swap by read width.
  function automatic logic [31:0] format_result(input logic [31:0] st,
                                                input crc_cfg_t cfg,
                                                input logic full_word);
    logic [31:0] v;
    if (cfg.poly16) v = {16'h0, cfg.bitrev ? rev16(st[15:0]) : st[15:0]};
    else            v = cfg.bitrev ? rev32(st) : st;
    if (cfg.swap) begin
      if (cfg.poly16)     v = {16'h0, v[7:0], v[15:8]};
      else if (full_word) v = {v[7:0], v[15:8], v[23:16], v[31:24]};
      else                v = {v[23:16], v[31:24], v[7:0], v[15:8]};
    end
    return v;
  endfunction
endpackage

// File: rtl/crc_decode.sv
module crc_decode
  import crc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int WIN_BASE  = 'h1800,
  parameter int WIN_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [LANES-1:0]  bus_be,
  input  crc_cfg_t          cfg_wdata,
  output crc_cfg_t          cfg,
  output logic              ctrl_wr,
  output logic              seed_load,
  output logic              data_fold,
  output logic              rd_ctrl,
  output logic              rd_result
);
  localparam int WIN_LAST = WIN_BASE + 4 * (WIN_WORDS - 1);

  logic hit_ctrl, hit_seed, hit_din, hit_res, hit_win, wr_any, rd_any;

  assign hit_ctrl = (bus_addr == ADDR_W'(OFS_CTRL));
  assign hit_seed = (bus_addr == ADDR_W'(OFS_SEED));
  assign hit_din  = (bus_addr == ADDR_W'(OFS_DIN));
  assign hit_res  = (bus_addr == ADDR_W'(OFS_RESULT));
  assign hit_win  = (bus_addr >= ADDR_W'(WIN_BASE)) &&
                    (bus_addr <= ADDR_W'(WIN_LAST)) &&
                    (bus_addr[1:0] == 2'b00);

  assign wr_any = bus_sel &&  bus_wr;
  assign rd_any = bus_sel && !bus_wr;

  assign ctrl_wr   = wr_any && hit_ctrl && bus_be[0];
  assign seed_load = wr_any && hit_seed && (|bus_be);
  assign data_fold = wr_any && (hit_din || hit_win) && (|bus_be);
  assign rd_ctrl   = rd_any && hit_ctrl;
  assign rd_result = rd_any && hit_res;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cfg <= '0;
    else if (ctrl_wr) cfg <= cfg_wdata;
  end
endmodule

// File: rtl/crc_core.sv
module crc_core
  import crc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             seed_load,
  input  logic             data_fold,
  input  crc_cfg_t         cfg,
  input  logic [BUS_W-1:0] wdata,
  input  logic [LANES-1:0] be,
  output logic [31:0]      state
);
  logic [LANES:0][31:0] chain;

  assign chain[0] = state;

  for (genvar k = 0; k < LANES; k++) begin : g_step
    localparam int LO = k;
    localparam int HI = LANES - 1 - k;
    logic [7:0] raw;
    logic [7:0] feed;
    logic       en;
    assign raw  = cfg.msb_first ? wdata[HI*8 +: 8] : wdata[LO*8 +: 8];
    assign en   = cfg.msb_first ? be[HI] : be[LO];
    assign feed = cfg.bitrev ? rev8(raw) : raw;
    assign chain[k+1] = en ? fold_byte(chain[k], feed, cfg.poly16) : chain[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         state <= '0;
    else if (seed_load) state <= cfg.poly16 ? {16'h0, wdata[15:0]} : wdata;
    else if (data_fold) state <= chain[LANES];
  end
endmodule

// File: rtl/crc_readout.sv
module crc_readout
  import crc_pkg::*;
(
  input  logic [31:0]      state,
  input  crc_cfg_t         cfg,
  input  logic [LANES-1:0] be,
  input  logic             rd_ctrl,
  input  logic             rd_result,
  output logic [BUS_W-1:0] rdata
);
  logic full_word;
  assign full_word = (be == {LANES{1'b1}});

  always_comb begin
    rdata = '0;
    if (rd_result)    rdata = format_result(state, cfg, full_word);
    else if (rd_ctrl) rdata = {27'h0, cfg.swap, 1'b0, cfg.msb_first, cfg.bitrev, cfg.poly16};
  end
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_pkg::*;
#(
  parameter int ADDR_W    = 13,
  parameter int WIN_BASE  = 'h1800,
  parameter int WIN_WORDS = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata
);
  crc_cfg_t    cfg, cfg_wdata;
  logic        ctrl_wr, seed_load, data_fold, rd_ctrl, rd_result;
  logic [31:0] crc_state;

  assign cfg_wdata = '{swap: bus_wdata[4], msb_first: bus_wdata[2],
                       bitrev: bus_wdata[1], poly16: bus_wdata[0]};

  crc_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)) u_decode (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .cfg_wdata(cfg_wdata), .cfg(cfg),
    .ctrl_wr(ctrl_wr), .seed_load(seed_load), .data_fold(data_fold),
    .rd_ctrl(rd_ctrl), .rd_result(rd_result)
  );

  crc_core u_core (
    .clk(clk), .rst_n(rst_n), .seed_load(seed_load), .data_fold(data_fold),
    .cfg(cfg), .wdata(bus_wdata), .be(bus_be), .state(crc_state)
  );

  crc_readout u_readout (
    .state(crc_state), .cfg(cfg), .be(bus_be), .rd_ctrl(rd_ctrl),
    .rd_result(rd_result), .rdata(bus_rdata)
  );
endmodule

// File: rtl/crc_engine_checks.sv
module crc_engine_checks #(
  parameter int ADDR_W    = 13,
  parameter int WIN_BASE  = 'h1800,
  parameter int WIN_WORDS = 512
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        bus_be,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ctrl_wr,
  input logic              seed_load,
  input logic              data_fold,
  input logic              mode16,
  input logic [31:0]       crc_state
);
  localparam int WIN_LAST = WIN_BASE + 4 * (WIN_WORDS - 1);

  logic win_wr, res_rd;
  assign win_wr = bus_sel && bus_wr && (|bus_be) && (bus_addr[1:0] == 2'b00) &&
                  (bus_addr >= ADDR_W'(WIN_BASE)) && (bus_addr <= ADDR_W'(WIN_LAST));
  assign res_rd = bus_sel && !bus_wr && (bus_addr == ADDR_W'('h00C));

  assert_ctrl_keeps_state_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> crc_state == $past(crc_state));

  assert_quiet_keeps_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(seed_load || data_fold) |=> $stable(crc_state));

  assert_seed_loads_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> crc_state == ($past(mode16) ? {16'h0, $past(bus_wdata[15:0])} : $past(bus_wdata)));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_rd && mode16) |-> bus_rdata[31:16] == 16'h0);

  assert_window_folds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_wr |-> data_fold);

  assert_one_event_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctrl_wr, seed_load, data_fold}));
endmodule

bind crc_engine crc_engine_checks #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_WORDS(WIN_WORDS)) u_checks (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_wr(ctrl_wr),
  .seed_load(seed_load), .data_fold(data_fold), .mode16(cfg.poly16), .crc_state(crc_state)
);

// File: tb/test_crc_engine.sv
module test_crc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  // behavioural model
  logic [31:0] m_state = 0;
  bit m_p16 = 0, m_rev = 0, m_msb = 0, m_swap = 0;

  always #5 clk = ~clk;

  crc_engine i_crc_engine (.clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_fold_bits(logic [31:0] c, logic [7:0] d);
    int w = m_p16 ? 16 : 32;
    logic [7:0] dd = d;
    if (m_rev) for (int i = 0; i < 8; i++) dd[i] = d[7-i];
    for (int i = 7; i >= 0; i--) begin
      bit fb = c[w-1] ^ dd[i];
      c = c << 1;
      if (m_p16) c = c & 32'hFFFF;
      if (fb) c = c ^ (m_p16 ? 32'h1021 : 32'h04C11DB7);
    end
    return c;
  endfunction

  function automatic logic [31:0] m_read(logic [3:0] be);
    int w = m_p16 ? 16 : 32;
    logic [31:0] v = m_p16 ? (m_state & 32'hFFFF) : m_state;
    logic [31:0] r = 0;
    logic [7:0] b[4];
    if (m_rev) begin
      for (int i = 0; i < w; i++) r[w-1-i] = v[i];
      v = r;
    end
    for (int i = 0; i < 4; i++) b[i] = v[8*i +: 8];
    if (m_swap) begin
      if (m_p16)           v = {16'h0, b[0], b[1]};
      else if (be == 4'hF) v = {b[0], b[1], b[2], b[3]};
      else                 v = {b[2], b[3], b[0], b[1]};
    end
    return v;
  endfunction

  task automatic wr(input logic [12:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    if (a == 13'h000 && be[0]) begin
      m_p16 = d[0]; m_rev = d[1]; m_msb = d[2]; m_swap = d[4];
    end else if (a == 13'h004 && be != 0) begin
      m_state = m_p16 ? (d & 32'hFFFF) : d;
    end else if ((a == 13'h008 || (a >= 13'h1800 && a[1:0] == 0)) && be != 0) begin
      for (int k = 0; k < 4; k++) begin
        int lane = m_msb ? 3 - k : k;
        if (be[lane]) m_state = m_fold_bits(m_state, d[8*lane +: 8]);
      end
    end
  endtask

  task automatic rd(input logic [12:0] a, input logic [3:0] be, output logic [31:0] q);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_be = be; bus_wdata = 0;
    #2 q = bus_rdata;
  endtask

  task automatic cmp_result(input logic [3:0] be, input string req);
    logic [31:0] q, e;
    rd(13'h00C, be, q);
    e = m_read(be);
    check(q === e, req, q, e);
  endtask

  task automatic feed_123456789(input logic [12:0] a);
    wr(a, 32'h34333231, 4'hF);
    wr(a, 32'h38373635, 4'hF);
    wr(a, 32'h00000039, 4'h1);
  endtask

  initial begin : wdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] q;
    logic [31:0] lcg = 32'h1234_5678;
    logic [3:0] be_set[7] = '{4'h1, 4'h2, 4'h4, 4'h8, 4'h3, 4'hC, 4'hF};
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    rd(13'h000, 4'hF, q); check(q == 0, "R1 ctrl", q, 0);
    rd(13'h00C, 4'hF, q); check(q == 0, "R1 result", q, 0);

    // R2 CRC-32 vector, R5 back-to-back folds
    wr(13'h004, 32'hFFFFFFFF, 4'hF);
    rd(13'h00C, 4'hF, q); check(q == 32'hFFFFFFFF, "R4 seed", q, 32'hFFFFFFFF);
    feed_123456789(13'h008);
    rd(13'h00C, 4'hF, q); check(q == 32'h0376E6E7, "R2 R5 vector", q, 32'h0376E6E7);
    cmp_result(4'hF, "R2 model");

    // R7 reversed in/out gives standard reflected CRC before final xor
    wr(13'h000, 32'h2, 4'h1);
    wr(13'h004, 32'hFFFFFFFF, 4'hF);
    feed_123456789(13'h008);
    rd(13'h00C, 4'hF, q); check(q == 32'h340BC6D9, "R7 vector", q, 32'h340BC6D9);

    // R3 CRC-16 vector, R4 low-half seed
    wr(13'h000, 32'h1, 4'h1);
    wr(13'h004, 32'hABCD1234, 4'hF);
    rd(13'h00C, 4'hF, q); check(q == 32'h00001234, "R4 seed16", q, 32'h1234);
    wr(13'h004, 32'h0000FFFF, 4'hF);
    feed_123456789(13'h008);
    rd(13'h00C, 4'hF, q); check(q == 32'h000029B1, "R3 vector", q, 32'h29B1);

    // R8 swap in 16-bit mode
    wr(13'h000, 32'h11, 4'h1);
    rd(13'h00C, 4'hF, q); check(q == 32'h0000B129, "R8 swap16 R10", q, 32'hB129);

    // R8 swap in 32-bit mode, word and half reads
    wr(13'h000, 32'h10, 4'h1);
    wr(13'h004, 32'h11223344, 4'hF);
    rd(13'h00C, 4'hF, q); check(q == 32'h44332211, "R8 word swap", q, 32'h44332211);
    rd(13'h00C, 4'h3, q); check(q == 32'h22114433, "R8 half swap", q, 32'h22114433);

    // R6 byte order
    wr(13'h000, 32'h4, 4'h1);
    wr(13'h004, 32'hFFFFFFFF, 4'hF);
    wr(13'h008, 32'h31323334, 4'hF);
    wr(13'h008, 32'h35363738, 4'hF);
    wr(13'h008, 32'h39000000, 4'h8);
    rd(13'h00C, 4'hF, q); check(q == 32'h0376E6E7, "R6 msb-first", q, 32'h0376E6E7);

    // R9 window aliases
    wr(13'h000, 32'h0, 4'h1);
    wr(13'h004, 32'hFFFFFFFF, 4'hF);
    wr(13'h1800, 32'h34333231, 4'hF);
    wr(13'h1FFC, 32'h38373635, 4'hF);
    wr(13'h1A40, 32'h00000039, 4'h1);
    rd(13'h00C, 4'hF, q); check(q == 32'h0376E6E7, "R9 window", q, 32'h0376E6E7);

    // R11 control readback and lane-0 only
    wr(13'h000, 32'hFFFFFFFF, 4'hF);
    rd(13'h000, 4'hF, q); check(q == 32'h17, "R11 readback", q, 32'h17);
    wr(13'h000, 32'h00000000, 4'hE);
    rd(13'h000, 4'hF, q); check(q == 32'h17, "R11 lane0 only", q, 32'h17);
    rd(13'h004, 4'hF, q); check(q == 0, "R11 seed reads 0", q, 0);
    cmp_result(4'hC, "R10 R11 result");

    // Pseudo-random sweep against the model, result compared after every access
    for (int n = 0; n < 600; n++) begin
      int sel;
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      sel = int'(lcg[31:28]);
      if (sel < 2)      wr(13'h000, {24'h0, lcg[7:0]}, 4'h1);
      else if (sel < 3) wr(13'h004, lcg ^ 32'h5A5A5A5A, 4'hF);
      else if (sel < 9) wr(13'h008, lcg * 32'd7, be_set[lcg[10:8] % 7]);
      else              wr(13'h1800 + {lcg[19:11], 2'b00}, lcg * 32'd13, 4'hF);
      cmp_result(be_set[4 + (lcg[22:21] % 3)], "R5 R6 R7 R8 R9 sweep");
    end

    @(negedge clk);
    bus_sel = 0;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule